// File: doc/BRIEF.md
# Countdown Timer and Interrupt Status Hub

This block pairs a programmable countdown timer with a summary interrupt status register. Software programs the timer through a single 32-bit control word that carries the start count, a count enable, an interrupt enable and a self-clearing acknowledge bit. While enabled, the count steps down by one on each cycle in which the tick enable input is high. The timer raises its pending flag when the count steps from one to zero, but only if interrupts are enabled.

The status register gathers five external interrupt levels (playback, recording, serial audio out, game port and MIDI) and the timer flag into fixed bit positions. The block ORs these bits into a single shared interrupt output. The external sources clear their own levels. The timer flag is cleared through the acknowledge bit of the control word.

Top module: `countdown_irq_hub`

## Requirements
- R1: After reset the control word reads 0x0000_0000, the status register reads 0 and irq_o is low.
- R2: A write to address 0 loads the count from bits 19:0, the count enable from bit 24 and the interrupt enable from bit 25. A read of address 0 returns the current count in bits 19:0 and the two enables in bits 24 and 25. Bit 26 and bits 31:27 and 23:20 read as zero.
- R3: On a clock edge with the count enable set, tick_i high, no control write and a nonzero count, the count drops by one. It holds at zero, and it holds whenever tick_i or the enable is low. A control write in the same cycle takes precedence over the tick.
- R4: The timer flag sets only on the step from 1 to 0, and only with the interrupt enable set. It does not set when zero is loaded, when the count stays at zero, or when the interrupt enable is clear.
- R5: A control write with bit 26 set clears the timer flag. A control write with bit 26 clear leaves the flag unchanged.
- R6: A read of address 1 returns status bits 4:0 equal to src_i[4:0] (bit 0 playback, bit 1 recording, bit 2 serial audio out, bit 3 game port, bit 4 MIDI) and bit 5 equal to the timer flag. All other bits read zero. Writes to address 1 change nothing.
- R7: irq_o is high exactly when any status bit is set.
- R8: Reads of addresses 2 and 3 return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| tick_i | input | 1 | Countdown tick enable |
| src_i | input | 5 | External interrupt levels |
| irq_o | output | 1 | Shared interrupt output |

## Verification
The assertions check several rules on every cycle: each count step is exactly one, the count holds when it is not allowed to step, the flag only rises out of a count of one, the acknowledge clears the flag, the interrupt output follows the sources and the flag, and the unused control bits read zero. The bench scenarios cover the behaviour that depends on sequences: a full countdown with the flag set at the right edge, a write that takes precedence over a tick, the absence of a flag when zero is loaded or when the interrupt enable is clear, the flag held across a write without acknowledge, and writes to the status and unmapped addresses that must change nothing.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned STAT_W       = 8;
  localparam int unsigned CTRL_EN_BIT  = 24;
  localparam int unsigned CTRL_IE_BIT  = 25;
  localparam int unsigned CTRL_ACK_BIT = 26;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_RSV2 = 2'd2,
    ADDR_RSV3 = 2'd3
  } reg_addr_e;

  // fixed status positions
  localparam int unsigned ST_PLAY  = 0;
  localparam int unsigned ST_REC   = 1;
  localparam int unsigned ST_SAO   = 2;
  localparam int unsigned ST_GAME  = 3;
  localparam int unsigned ST_MIDI  = 4;
  localparam int unsigned ST_TIMER = 5;
  localparam int unsigned N_EXT_SRC = 5;
endpackage

// File: rtl/cdt_countdown.sv
module cdt_countdown #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             load_en_i,
  input  logic             load_ie_i,
  input  logic             ack_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             ie_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  logic hit_zero;

  assign step     = !load_i && en_o && tick_i && (cnt_o != '0);
  assign hit_zero = step && (cnt_o == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      en_o  <= 1'b0;
      ie_o  <= 1'b0;
    end else if (load_i) begin
      cnt_o <= load_cnt_i;
      en_o  <= load_en_i;
      ie_o  <= load_ie_i;
    end else if (step) begin
      cnt_o <= cnt_o - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
    end else if (load_i && ack_i) begin
      flag_o <= 1'b0;
    end else if (hit_zero && ie_o) begin
      flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cdt_irq_collect.sv
module cdt_irq_collect #(
  parameter int unsigned N_SRC   = 5,
  parameter int unsigned STAT_W  = 8,
  parameter int unsigned TMR_BIT = 5
) (
  input  logic [N_SRC-1:0]  src_i,
  input  logic              tmr_flag_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i < N_SRC) begin : g_src
      assign stat_o[i] = src_i[i];
    end else if (i == TMR_BIT) begin : g_tmr
      assign stat_o[i] = tmr_flag_i;
    end else begin : g_rsv
      assign stat_o[i] = 1'b0;
    end
  end

  assign irq_o = |stat_o;
endmodule

// File: rtl/countdown_irq_hub.sv
module countdown_irq_hub
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              tick_i,
  input  logic [N_EXT_SRC-1:0] src_i,
  output logic              irq_o
);
  logic             ctrl_we;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_en;
  logic             tmr_ie;
  logic             tmr_flag;
  logic [STAT_W-1:0] stat;
  logic             unused_wbits;

  assign ctrl_we = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_CTRL));
  assign unused_wbits = ^{reg_wdata_i[REG_W-1:CTRL_ACK_BIT+1],
                          reg_wdata_i[CTRL_EN_BIT-1:CNT_W]};

  cdt_countdown #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctrl_we),
    .load_cnt_i (reg_wdata_i[CNT_W-1:0]),
    .load_en_i  (reg_wdata_i[CTRL_EN_BIT]),
    .load_ie_i  (reg_wdata_i[CTRL_IE_BIT]),
    .ack_i      (reg_wdata_i[CTRL_ACK_BIT]),
    .tick_i     (tick_i),
    .cnt_o      (tmr_cnt),
    .en_o       (tmr_en),
    .ie_o       (tmr_ie),
    .flag_o     (tmr_flag)
  );

  cdt_irq_collect #(
    .N_SRC   (N_EXT_SRC),
    .STAT_W  (STAT_W),
    .TMR_BIT (ST_TIMER)
  ) u_irq (
    .src_i      (src_i),
    .tmr_flag_i (tmr_flag),
    .stat_o     (stat),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(ADDR_CTRL)) begin
      reg_rdata_o[CNT_W-1:0]   = tmr_cnt;
      reg_rdata_o[CTRL_EN_BIT] = tmr_en;
      reg_rdata_o[CTRL_IE_BIT] = tmr_ie;
    end else if (reg_addr_i == ADDR_W'(ADDR_STAT)) begin
      reg_rdata_o[STAT_W-1:0]  = stat;
    end
  end
endmodule

// File: rtl/countdown_irq_hub_chk.sv
module countdown_irq_hub_chk
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic              tick_i,
  input logic [N_EXT_SRC-1:0] src_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  tmr_cnt,
  input logic              tmr_en,
  input logic              tmr_flag
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_CTRL));

  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_wr && tmr_en && tick_i && tmr_cnt != '0) |=>
      (tmr_cnt == $past(tmr_cnt) - CNT_W'(1)));

  p_count_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_wr && (!tmr_en || !tick_i || tmr_cnt == '0)) |=> $stable(tmr_cnt));

  p_flag_origin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && !tmr_flag) ##1 tmr_flag |-> ($past(tmr_cnt) == CNT_W'(1)) && (tmr_cnt == '0));

  p_ack_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i[CTRL_ACK_BIT]) |=> !tmr_flag);

  p_irq_or_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((src_i != '0) || tmr_flag));

  p_ctrl_rsv_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(ADDR_CTRL)) |->
      (reg_rdata_o[REG_W-1:CTRL_ACK_BIT] == '0) && (reg_rdata_o[CTRL_EN_BIT-1:CNT_W] == '0));
endmodule

bind countdown_irq_hub countdown_irq_hub_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .tick_i      (tick_i),
  .src_i       (src_i),
  .irq_o       (irq_o),
  .tmr_cnt     (tmr_cnt),
  .tmr_en      (tmr_en),
  .tmr_flag    (tmr_flag)
);

// File: tb/tb_countdown_irq_hub.sv
module tb_countdown_irq_hub;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EN  = 32'h0100_0000;
  localparam logic [31:0] IE  = 32'h0200_0000;
  localparam logic [31:0] ACK = 32'h0400_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        tick_i = 1'b0;
  logic [4:0]  src_i = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  countdown_irq_hub dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .tick_i(tick_i),
    .src_i(src_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); chk("R1 ctrl", d, 32'h0);
    rd(2'd1, d); chk("R1 status", d, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 readback mask, ack reads 0", d, 32'h030F_FFFF);
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, d); chk("R2 cleared", d, 32'h0);
  endtask

  task automatic t_countdown;
    logic [31:0] d;
    wr(2'd0, EN | IE | 32'd3);
    rd(2'd0, d); chk("R2 load 3", d, EN | IE | 32'd3);
    tick_i = 1'b1;
    @(negedge clk_i);
    rd(2'd0, d); chk("R3 step to 2", d[19:0], 32'd2);
    @(negedge clk_i);
    rd(2'd0, d); chk("R3 step to 1", d[19:0], 32'd1);
    rd(2'd1, d); chk("R4 no flag at 1", d, 32'h0);
    @(negedge clk_i);
    rd(2'd0, d); chk("R3 step to 0", d[19:0], 32'd0);
    rd(2'd1, d); chk("R4 flag at zero", d, 32'h20);
    chk("R7 irq from timer", {31'b0, irq_o}, 32'h1);
    repeat (3) @(negedge clk_i);
    tick_i = 1'b0;
    rd(2'd0, d); chk("R3 holds at zero", d[19:0], 32'd0);
    // write without ack keeps flag
    wr(2'd0, EN | IE | 32'd7);
    rd(2'd1, d); chk("R5 flag held without ack", d, 32'h20);
    rd(2'd0, d); chk("R2 reload 7", d[19:0], 32'd7);
    wr(2'd0, EN | IE | ACK);
    rd(2'd1, d); chk("R5 ack clears flag", d, 32'h0);
    rd(2'd0, d); chk("R2 ack reads zero", d, EN | IE);
    chk("R7 irq low after ack", {31'b0, irq_o}, 32'h0);
    ticks(4);
    rd(2'd1, d); chk("R4 no flag while staying at zero", d, 32'h0);
  endtask

  task automatic t_no_ie;
    logic [31:0] d;
    wr(2'd0, EN | 32'd2);
    ticks(3);
    rd(2'd0, d); chk("R3 count reached zero", d, EN);
    rd(2'd1, d); chk("R4 no flag with ie clear", d, 32'h0);
    chk("R7 irq low", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_no_en;
    logic [31:0] d;
    wr(2'd0, IE | 32'd5);
    ticks(3);
    rd(2'd0, d); chk("R3 no step without enable", d, IE | 32'd5);
    wr(2'd0, EN | IE | 32'd5);
    repeat (3) @(negedge clk_i);
    rd(2'd0, d); chk("R3 no step without tick", d[19:0], 32'd5);
  endtask

  task automatic t_load_zero;
    logic [31:0] d;
    wr(2'd0, EN | IE);
    ticks(3);
    rd(2'd1, d); chk("R4 no flag on loaded zero", d, 32'h0);
  endtask

  task automatic t_write_wins;
    logic [31:0] d;
    wr(2'd0, EN | IE | 32'd20);
    tick_i = 1'b1;
    wr(2'd0, EN | IE | 32'd10);
    tick_i = 1'b0;
    rd(2'd0, d); chk("R3 write beats tick", d[19:0], 32'd10);
  endtask

  task automatic t_sources;
    logic [31:0] d;
    wr(2'd0, 32'h0);
    for (int i = 0; i < 5; i++) begin
      src_i = 5'(1 << i);
      rd(2'd1, d); chk("R6 single source bit", d, 32'(1 << i));
      chk("R7 irq single source", {31'b0, irq_o}, 32'h1);
    end
    src_i = 5'b10101;
    rd(2'd1, d); chk("R6 mixed sources", d, 32'h15);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R6 status write ignored", d, 32'h15);
    src_i = '0;
    rd(2'd1, d); chk("R6 sources cleared", d, 32'h0);
    chk("R7 irq low no sources", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(2'd0, IE | 32'd9);
    wr(2'd2, EN | ACK | 32'd1);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R8 addr 2 reads zero", d, 32'h0);
    rd(2'd3, d); chk("R8 addr 3 reads zero", d, 32'h0);
    rd(2'd0, d); chk("R8 unmapped write ignored", d, IE | 32'd9);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_readback();
    t_countdown();
    t_no_ie();
    t_no_en();
    t_load_zero();
    t_write_wins();
    t_sources();
    t_unmapped();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule